// File: doc/BRIEF.md
# Byte-Wide Configuration Loader

This block configures a downstream programmable device over a byte-wide write port. On a start pulse it pulls the device's active-low program line low for a fixed time and then releases it. It then waits for the device's active-low init line to read high. If that does not happen within a run-time timeout, it finishes with an error and writes nothing.

Once the device is ready, the loader writes an eight-byte fixed header. It then sends framed configuration data. Each frame carries 21 bytes taken from a valid/ready byte stream. Each frame's data is enclosed by a preamble code, a check code and a five-byte trailer. If the stream ends partway through a frame, the missing data bytes are filled with 0xFF.

Before each frame the loader looks at the device's status lines. It stops framing when init drops, when done rises, or when the stream has ended. It then writes four startup bytes and reports finished, with an error if done is still low at that point. Each written byte is held on the data bus for a run-time number of clocks around a one-cycle write strobe.

Top module: `cfg_byte_loader`

## Requirements
- R1: After reset, progN is 1, cfgWr is 0, sReady is 0, and busy, finished and cfgErr are all 0.
- R2: A start pulse drives progN to 0 for exactly PROG_CYCLES clock cycles, after which progN returns to 1.
- R3: No write strobe occurs while progN is 0. After progN is released, no write strobe occurs until initN has been sampled at 1.
- R4: The first eight bytes written are, in order: 0xFF, 0xFF, 0xFF, 0x4F, 0x80, 0xAF, 0x9B, 0x4B.
- R5: Each frame is 28 writes: 0x4F, then 21 stream bytes in arrival order, then 0x4B, 0xFF, 0x4B, 0xFF, 0xFF, 0xFF. Gaps in sValid do not alter this sequence.
- R6: A frame is begun only if initN is 1, doneIn is 0, and the stream byte flagged by sLast has not yet been accepted. A frame that has begun is always completed. Stream bytes are accepted (sValid and sReady both 1) only in a frame's data positions, so bytes beyond the stop point stay unconsumed.
- R7: When the sLast byte is accepted before a frame's 21st data position, each remaining data position of that frame is written as 0xFF.
- R8: When framing stops, four 0xFF bytes are written. The loader then asserts finished, and sets cfgErr if doneIn reads 0 once the last of those writes has completed.
- R9: If initN is still 0 after timeoutCycles+1 cycles with progN released, finished and cfgErr rise exactly timeoutCycles+1 cycles after progN rose, and no byte is written.
- R10: cfgWr is high for single cycles only. cfgData is unchanged for at least holdCycles+1 cycles before each strobe cycle, and for at least holdCycles+1 cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a configuration run (accepted when idle or finished) |
| timeoutCycles | input | TMO_W | Cycles allowed for init to read high |
| holdCycles | input | HOLD_W | Extra clocks of data hold around each strobe |
| sData | input | 8 | Stream data byte |
| sValid | input | 1 | Stream byte present |
| sLast | input | 1 | Marks the final stream byte |
| sReady | output | 1 | Stream byte taken this cycle when sValid is high |
| initN | input | 1 | Device active-low init status |
| doneIn | input | 1 | Device done status |
| progN | output | 1 | Device active-low program line |
| cfgData | output | 8 | Byte on the configuration port |
| cfgWr | output | 1 | One-cycle write strobe |
| busy | output | 1 | A run is in progress |
| finished | output | 1 | Run complete |
| cfgErr | output | 1 | Run ended with an error |

## Verification
The hardest conditions to reach are the frame-boundary decisions. These are a status line changing exactly between two frames while data is still available, and a stream ending either on a frame edge or inside one. The bench models the device. It counts the strobes it observes, and at the strobe that closes the first frame it raises done or drops init. In other runs it raises done only once the startup bytes begin. Stream lengths of 21, 30, 42 and 63 bytes, with and without valid gaps, place the stream end exactly on a frame edge, mid-frame, and beyond the stop point.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

  localparam logic [7:0] PREAMBLE  = 8'h4F;
  localparam logic [7:0] CHECKCODE = 8'h4B;
  localparam logic [7:0] FILL      = 8'hFF;

  localparam int HDR_LEN    = 8;
  localparam int FRAME_DATA = 21;
  localparam int FRAME_LEN  = FRAME_DATA + 7;
  localparam int START_LEN  = 4;
  localparam int IDX_W      = $clog2(FRAME_LEN);

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_WAIT, S_HDR, S_FRM, S_NEXT, S_STUP, S_DRAIN, S_FIN
  } cbl_state_t;

  // Strobes from control to the byte datapath
  typedef struct packed {
    logic       load;
    logic [7:0] value;
  } cbl_cmd_t;

  function automatic logic [7:0] hdrByte(input logic [2:0] i);
    case (i)
      3'd3:    return PREAMBLE;
      3'd4:    return 8'h80;
      3'd5:    return 8'hAF;
      3'd6:    return 8'h9B;
      3'd7:    return CHECKCODE;
      default: return FILL;
    endcase
  endfunction

  // Non-data positions of a frame: 0 preamble, 22 check, 23..27 trailer
  function automatic logic [7:0] frameConst(input logic [IDX_W-1:0] i);
    if (i == 0) return PREAMBLE;
    if (i == IDX_W'(FRAME_DATA + 1) || i == IDX_W'(FRAME_DATA + 3)) return CHECKCODE;
    return FILL;
  endfunction

endpackage

// File: rtl/cbl_data.sv
module cbl_data
  import cbl_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cbl_cmd_t          cmd,
  input  logic [HOLD_W-1:0] holdCycles,
  output logic [7:0]        cfgData,
  output logic              cfgWr,
  output logic              idle
);

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_POST} bstage_t;

  bstage_t           stage;
  logic [HOLD_W-1:0] holdCnt;
  logic [7:0]        dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage   <= B_IDLE;
      holdCnt <= '0;
      dataQ   <= FILL;
    end else begin
      case (stage)
        B_IDLE: if (cmd.load) begin
          dataQ   <= cmd.value;
          holdCnt <= holdCycles;
          stage   <= B_SETUP;
        end
        B_SETUP: if (holdCnt == '0) stage <= B_STROBE;
                 else holdCnt <= holdCnt - 1'b1;
        B_STROBE: begin
          holdCnt <= holdCycles;
          stage   <= B_POST;
        end
        default: if (holdCnt == '0) stage <= B_IDLE;
                 else holdCnt <= holdCnt - 1'b1;
      endcase
    end
  end

  assign cfgData = dataQ;
  assign cfgWr   = (stage == B_STROBE);
  assign idle    = (stage == B_IDLE);

endmodule

// File: rtl/cbl_ctrl.sv
module cbl_ctrl
  import cbl_pkg::*;
#(
  parameter int PROG_CYCLES = 1000,
  parameter int TMO_W       = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [TMO_W-1:0] timeoutCycles,
  input  logic [7:0]       sData,
  input  logic             sValid,
  input  logic             sLast,
  output logic             sReady,
  input  logic             initN,
  input  logic             doneIn,
  input  logic             dpIdle,
  output cbl_cmd_t         cmd,
  output logic             progN,
  output logic             busy,
  output logic             finished,
  output logic             cfgErr
);

  localparam int PW    = $clog2(PROG_CYCLES + 1);
  localparam int CNT_W = (PW > TMO_W) ? PW : TMO_W;

  cbl_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             ended;
  logic             errQ;

  logic             dataSlot, needData, emitting, canLoad, lastPos;
  logic [7:0]       byteVal;

  always_comb begin
    dataSlot = (state == S_FRM) && (idx >= IDX_W'(1)) && (idx <= IDX_W'(FRAME_DATA));
    needData = dataSlot && !ended;
    emitting = (state == S_HDR) || (state == S_FRM) || (state == S_STUP);
    canLoad  = emitting && dpIdle && (!needData || sValid);
    case (state)
      S_HDR:   byteVal = hdrByte(idx[2:0]);
      S_FRM:   byteVal = dataSlot ? (ended ? FILL : sData) : frameConst(idx);
      default: byteVal = FILL;
    endcase
    case (state)
      S_HDR:   lastPos = (idx == IDX_W'(HDR_LEN - 1));
      S_FRM:   lastPos = (idx == IDX_W'(FRAME_LEN - 1));
      default: lastPos = (idx == IDX_W'(START_LEN - 1));
    endcase
  end

  assign sReady    = needData && dpIdle;
  assign cmd.load  = canLoad;
  assign cmd.value = byteVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      ended <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_FIN: if (start) begin
          state <= S_PROG;
          cnt   <= '0;
          ended <= 1'b0;
          errQ  <= 1'b0;
        end
        S_PROG: if (cnt == CNT_W'(PROG_CYCLES - 1)) begin
          state <= S_WAIT;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_WAIT: if (initN) begin
          state <= S_HDR;
          idx   <= '0;
        end else if (cnt >= CNT_W'(timeoutCycles)) begin
          state <= S_FIN;
          errQ  <= 1'b1;
        end else cnt <= cnt + 1'b1;
        S_HDR, S_FRM, S_STUP: if (canLoad) begin
          if (needData && sLast) ended <= 1'b1;
          if (lastPos) begin
            idx   <= '0;
            state <= (state == S_STUP) ? S_DRAIN : S_NEXT;
          end else idx <= idx + 1'b1;
        end
        S_NEXT: if (dpIdle) begin
          state <= (initN && !doneIn && !ended) ? S_FRM : S_STUP;
        end
        S_DRAIN: if (dpIdle) begin
          state <= S_FIN;
          errQ  <= !doneIn;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign progN    = (state != S_PROG);
  assign busy     = (state != S_IDLE) && (state != S_FIN);
  assign finished = (state == S_FIN);
  assign cfgErr   = errQ;

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
  import cbl_pkg::*;
#(
  parameter int PROG_CYCLES = 1000,
  parameter int TMO_W       = 20,
  parameter int HOLD_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [TMO_W-1:0]  timeoutCycles,
  input  logic [HOLD_W-1:0] holdCycles,
  input  logic [7:0]        sData,
  input  logic              sValid,
  input  logic              sLast,
  output logic              sReady,
  input  logic              initN,
  input  logic              doneIn,
  output logic              progN,
  output logic [7:0]        cfgData,
  output logic              cfgWr,
  output logic              busy,
  output logic              finished,
  output logic              cfgErr
);

  cbl_cmd_t cmd;
  logic     dpIdle;

  cbl_ctrl #(.PROG_CYCLES(PROG_CYCLES), .TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .timeoutCycles(timeoutCycles),
    .sData(sData), .sValid(sValid), .sLast(sLast), .sReady(sReady),
    .initN(initN), .doneIn(doneIn), .dpIdle(dpIdle), .cmd(cmd),
    .progN(progN), .busy(busy), .finished(finished), .cfgErr(cfgErr)
  );

  cbl_data #(.HOLD_W(HOLD_W)) u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .holdCycles(holdCycles),
    .cfgData(cfgData), .cfgWr(cfgWr), .idle(dpIdle)
  );

endmodule

// File: rtl/cfg_byte_loader_chk.sv
module cfg_byte_loader_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sReady,
  input logic       progN,
  input logic [7:0] cfgData,
  input logic       cfgWr,
  input logic       busy,
  input logic       finished,
  input logic       cfgErr
);

  p_no_write_in_program_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |-> progN);

  p_ready_after_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    sReady |-> (busy && progN));

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> !cfgWr);

  p_data_steady_at_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |-> $stable(cfgData));

  p_data_steady_after_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> $stable(cfgData));

  p_err_only_finished_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> finished);

endmodule

bind cfg_byte_loader cfg_byte_loader_chk u_chk (.*);

// File: tb/cfg_byte_loader_test.sv
module cfg_byte_loader_test;

  localparam int PROG   = 20;
  localparam int TMO_W  = 12;
  localparam int HOLD_W = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN = 1'b0, start = 1'b0;
  logic [TMO_W-1:0]  timeoutCycles = 12'd1000;
  logic [HOLD_W-1:0] holdCycles = '0;
  logic [7:0]        sData = '0;
  logic              sValid = 1'b0, sLast = 1'b0, sReady;
  logic              initN = 1'b0, doneIn = 1'b0;
  logic              progN, cfgWr, busy, finished, cfgErr;
  logic [7:0]        cfgData;

  cfg_byte_loader #(.PROG_CYCLES(PROG), .TMO_W(TMO_W), .HOLD_W(HOLD_W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .timeoutCycles(timeoutCycles),
    .holdCycles(holdCycles), .sData(sData), .sValid(sValid), .sLast(sLast),
    .sReady(sReady), .initN(initN), .doneIn(doneIn), .progN(progN),
    .cfgData(cfgData), .cfgWr(cfgWr), .busy(busy), .finished(finished),
    .cfgErr(cfgErr)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFails = 0;
  bit allDone = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dataOf(input int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  // device model and write monitor
  logic [7:0] cap[$];
  logic [7:0] prevData = 8'hFF;
  int lastChg = 0, lastWr = 0, stabBad = 0, curHold = 0, mode = 0, expTotal = 0;
  bit wrSeen = 0;

  always @(negedge clk) begin
    if (cfgData !== prevData) begin
      if (wrSeen && (cyc - lastWr) < curHold + 1) stabBad++;
      prevData = cfgData;
      lastChg  = cyc;
      wrSeen   = 0;
    end
    if (cfgWr) begin
      if ((cyc - lastChg) < curHold + 1) stabBad++;
      cap.push_back(cfgData);
      lastWr = cyc;
      wrSeen = 1;
      if (mode == 1 && cap.size() == 36) doneIn = 1'b1;
      if (mode == 2 && cap.size() == 36) initN = 1'b0;
      if (mode == 0 && cap.size() == expTotal - 3) doneIn = 1'b1;
    end
  end

  // stream source
  int ptr = 0, nData = 0;
  bit gaps = 0, acc = 0;
  always @(posedge clk) acc <= sValid && sReady;
  always @(negedge clk) begin
    if (!rstN) ptr = 0;
    else if (acc) ptr = ptr + 1;
    sValid = (ptr < nData) && (!gaps || ((ptr + cyc) % 3 != 1));
    sData  = dataOf(ptr);
    sLast  = (ptr == nData - 1);
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cap.delete();
    stabBad = 0;
    wrSeen  = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runScn(input int n, input int h, input bit g, input int m,
                        input int frames, input int consumed, input int errExp,
                        input string tag);
    logic [7:0] exp[$];
    int lowCnt, guard;
    mode = m; curHold = h; holdCycles = HOLD_W'(h);
    timeoutCycles = 12'd1000; nData = n; gaps = g;
    doneIn = 1'b0; initN = 1'b0;
    // expected write sequence
    exp = '{8'hFF, 8'hFF, 8'hFF, 8'h4F, 8'h80, 8'hAF, 8'h9B, 8'h4B};
    for (int f = 0; f < frames; f++) begin
      exp.push_back(8'h4F);
      for (int k = 0; k < 21; k++)
        exp.push_back((f * 21 + k < n) ? dataOf(f * 21 + k) : 8'hFF);
      exp.push_back(8'h4B); exp.push_back(8'hFF); exp.push_back(8'h4B);
      exp.push_back(8'hFF); exp.push_back(8'hFF); exp.push_back(8'hFF);
    end
    for (int k = 0; k < 4; k++) exp.push_back(8'hFF);
    expTotal = exp.size();
    doReset();
    pulseStart();
    lowCnt = 0;
    while (progN == 1'b0 && lowCnt < 10000) begin
      lowCnt++;
      @(negedge clk);
    end
    check(lowCnt == PROG, "R2", {tag, " program low cycles"}, lowCnt, PROG);
    repeat (30) @(negedge clk);
    check(cap.size() == 0, "R3", {tag, " writes before init high"}, cap.size(), 0);
    initN = 1'b1;
    guard = 0;
    while (!finished && guard < 20000) begin
      guard++;
      @(negedge clk);
    end
    check(finished == 1'b1, "R8", {tag, " finished (watchdog)"}, finished, 1);
    check(cfgErr == errExp[0], "R8", {tag, " error flag"}, cfgErr, errExp);
    check(cap.size() == exp.size(), "R6", {tag, " write count"}, cap.size(), exp.size());
    check(ptr == consumed, "R6", {tag, " stream bytes consumed"}, ptr, consumed);
    check(stabBad == 0, "R10", {tag, " data hold violations"}, stabBad, 0);
    for (int i = 0; i < exp.size() && i < cap.size(); i++) begin
      if (i < 8)
        check(cap[i] == exp[i], "R4", $sformatf("%s header byte %0d", tag, i), cap[i], exp[i]);
      else if (i >= exp.size() - 4)
        check(cap[i] == exp[i], "R8", $sformatf("%s startup byte %0d", tag, i), cap[i], exp[i]);
      else if (((i - 8) / 28) * 21 + ((i - 8) % 28) - 1 >= n && ((i - 8) % 28) >= 1
               && ((i - 8) % 28) <= 21)
        check(cap[i] == exp[i], "R7", $sformatf("%s pad byte %0d", tag, i), cap[i], exp[i]);
      else
        check(cap[i] == exp[i], "R5", $sformatf("%s frame byte %0d", tag, i), cap[i], exp[i]);
    end
  endtask

  initial begin : watchdog
    wait (cyc >= 150000);
    if (!allDone) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    int t0, guard;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(progN == 1'b1, "R1", "progN after reset", progN, 1);
    check(cfgWr == 1'b0, "R1", "cfgWr after reset", cfgWr, 0);
    check(sReady == 1'b0, "R1", "sReady after reset", sReady, 0);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(finished == 1'b0, "R1", "finished after reset", finished, 0);
    check(cfgErr == 1'b0, "R1", "cfgErr after reset", cfgErr, 0);

    runScn(42, 0, 0, 0, 2, 42, 0, "stream ends on frame edge");
    runScn(30, 2, 1, 0, 2, 30, 0, "stream ends mid-frame");
    runScn(21, 3, 0, 0, 1, 21, 0, "single frame");
    runScn(63, 1, 1, 1, 1, 21, 0, "done rises after frame");
    runScn(63, 0, 0, 2, 1, 21, 1, "init drops after frame");

    // R9 init never rises
    mode = 3; curHold = 0; holdCycles = '0; nData = 0; gaps = 0;
    doneIn = 1'b0; initN = 1'b0; timeoutCycles = 12'd50;
    doReset();
    pulseStart();
    guard = 0;
    while (progN == 1'b0 && guard < 10000) begin guard++; @(negedge clk); end
    t0 = cyc;
    guard = 0;
    while (!finished && guard < 10000) begin guard++; @(negedge clk); end
    check(cyc - t0 == 51, "R9", "timeout latency", cyc - t0, 51);
    check(cfgErr == 1'b1, "R9", "timeout error flag", cfgErr, 1);
    check(cap.size() == 0, "R9", "writes after timeout", cap.size(), 0);

    allDone = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule